// File: doc/BRIEF.md
# Quarter-Wave Sine Phase-to-Amplitude Generator

This block is the digital core of a table-driven sine synthesizer. A phase accumulator adds a programmed increment on every enabled clock and wraps silently. The integer part of the accumulated phase is turned into a sine sample in sign-magnitude form. Only one quarter of the waveform is kept in a lookup table. The rest of the period is rebuilt by mirroring the table address and by setting the sign bit.

The accumulator is `N+K+2` bits wide. Its top bit selects the half-period, which is also the output sign. The next bit selects a rising or a falling quarter. Below these lie `N` table-address bits and `K` fractional bits; the fractional bits only refine the step and never reach the table. On a falling quarter the address is mirrored by two's complement. The crest sample is never stored. A zero detector on the address forces the full-scale code there instead. The table is computed when the design is elaborated. Address formation and the table read each take one register stage, so the sample appears a fixed two clocks after the accumulator value.

Top module: `qsine_gen`

## Requirements
- R1: While `rst_n` is low, the accumulator and both pipeline stages clear. The outputs read `sign_o`=0 and `mag_o`=0.
- R2: On each clock with `en` high, the accumulator takes `acc + step` modulo 2^(N+K+2). The table index is `acc[N+K+1:K]`, so a fractional step of 2^(K-1) moves the index once per two clocks. Stepping past the top index wraps to index 0.
- R3: With `en` low the accumulator holds, and the outputs keep their value whatever `step` is.
- R4: `sign_o` equals accumulator bit N+K+1: 0 for the first half-period and 1 for the second.
- R5: When accumulator bit N+K is 0, the low N index bits `a` address the table directly, and `mag_o` = T(a).
- R6: When accumulator bit N+K is 1 and `a` is nonzero, the address is the two's complement 2^N − a, and `mag_o` = T(2^N − a). With N=10, index 1025 reads T(1023).
- R7: When accumulator bit N+K is 1 and `a` is 0 (index 2^N or 3·2^N), `mag_o` is all ones (2^L − 1) in both half-periods.
- R8: T(i) = round((2^L − 1)·sin(π·i/2^(N+1))) for 0 ≤ i < 2^N. T(0)=0, so index 0 gives sign 0 / magnitude 0, and index 2^(N+1) gives sign 1 / magnitude 0 (negative zero).
- R9: The outputs reflect the accumulator value written two rising edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Accumulate enable |
| step | input | N+K+2 | Phase increment per enabled clock |
| sign_o | output | 1 | Sign of the sample (1 = negative), registered |
| mag_o | output | L | Magnitude of the sample, registered |

## Verification
Take a step driven before rising edge t. It lands in the accumulator at edge t, and the sample for that value reaches the ports at edge t+2. The scoreboard therefore pushes the modelled accumulator value after each edge. It pops the entry only once three are queued, and it compares against the outputs on the falling edge after t+2. Directed checks for the crests, the negative zero, the fold, the wrap, fractional stepping and enable hold first park the accumulator. They then hold it for three clocks before sampling, so the pipeline has fully refilled with the parked value.

// File: rtl/qsine_gen.sv
module qsine_gen #(
  parameter int N = 10,
  parameter int L = 10,
  parameter int K = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [N+K+1:0]   step,
  output logic             sign_o,
  output logic [L-1:0]     mag_o
);
  localparam int  P     = N + K + 2;
  localparam int  DEPTH = 1 << N;
  localparam real PI    = 3.141592653589793;

  function automatic logic [L-1:0] qw_val(input int idx);
    real ang;
    real v;
    int  r;
    ang = PI * real'(idx) / real'(2 ** (N + 1));
    v   = real'(2 ** L - 1) * $sin(ang);
    r   = $rtoi(v + 0.5);
    return r[L-1:0];
  endfunction

  logic [L-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam logic [L-1:0] V = qw_val(i);
    assign rom[i] = V;
  end

  logic [P-1:0] acc;
  logic [N-1:0] low;
  logic [N-1:0] addr;
  logic         peak;

  assign low  = acc[P-3 -: N];
  assign addr = acc[P-2] ? (~low + 1'b1) : low;
  assign peak = acc[P-2] & (low == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc + step;

  logic         s1_sign;
  logic         s1_peak;
  logic [N-1:0] s1_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_sign <= 1'b0;
      s1_peak <= 1'b0;
      s1_addr <= '0;
    end else begin
      s1_sign <= acc[P-1];
      s1_peak <= peak;
      s1_addr <= addr;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sign_o <= 1'b0;
      mag_o  <= '0;
    end else begin
      sign_o <= s1_sign;
      mag_o  <= s1_peak ? '1 : rom[s1_addr];
    end
endmodule

// File: rtl/qsine_gen_chk.sv
module qsine_gen_chk #(
  parameter int N = 10,
  parameter int L = 10,
  parameter int K = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [N+K+1:0]   step,
  input logic [N+K+1:0]   acc,
  input logic             sign_o,
  input logic [L-1:0]     mag_o
);
  localparam int P = N + K + 2;

  p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en)) |-> (acc == $past(acc) + $past(step)))
    else $error("R2 accumulator step");

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> (acc == $past(acc)))
    else $error("R3 accumulator hold");

  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sign_o == $past(acc[P-1], 2))
    else $error("R4 sign bit");

  p_quarter_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc[P-2], 2) == 1'b0 && $past(acc[P-3 -: N], 2) == '0) |-> (mag_o == '0))
    else $error("R5 zero at quarter start");

  p_peak_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc[P-2], 2) && $past(acc[P-3 -: N], 2) == '0) |-> (mag_o == '1))
    else $error("R7 crest code");

  p_negzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc[P-1:P-2], 2) == 2'b10 && $past(acc[P-3 -: N], 2) == '0) |-> (sign_o && mag_o == '0))
    else $error("R8 negative zero");
endmodule

bind qsine_gen qsine_gen_chk #(.N(N), .L(L), .K(K)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .step(step),
  .acc(acc), .sign_o(sign_o), .mag_o(mag_o)
);

// File: tb/test_qsine_gen.sv
`timescale 1ns/1ps
module test_qsine_gen;
  localparam int  N  = 10;
  localparam int  L  = 10;
  localparam int  K  = 8;
  localparam int  P  = N + K + 2;
  localparam real PI = 3.141592653589793;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [P-1:0] step = '0;
  logic         sign_o;
  logic [L-1:0] mag_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [P-1:0] m_acc = '0;
  logic [P-1:0] sb[$];

  always #2.5 clk = ~clk;

  qsine_gen #(.N(N), .L(L), .K(K)) i_qsine_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .step(step),
    .sign_o(sign_o), .mag_o(mag_o)
  );

  function automatic logic [L-1:0] tab(input int i);
    int r;
    r = $rtoi(real'(2 ** L - 1) * $sin(PI * real'(i) / real'(2 ** (N + 1))) + 0.5);
    return r[L-1:0];
  endfunction

  function automatic logic [L:0] ref_out(input logic [P-1:0] a);
    logic [N-1:0] low;
    logic [L-1:0] m;
    low = a[P-3 -: N];
    if (!a[P-2])         m = tab(int'(low));
    else if (low == '0)  m = '1;
    else                 m = tab((1 << N) - int'(low));
    return {a[P-1], m};
  endfunction

  function automatic string region(input logic [P-1:0] a);
    if (a[P-3 -: N] == '0) return a[P-2] ? "R7" : "R8";
    return a[P-2] ? "R6" : "R5";
  endfunction

  task automatic chk(input string tag, input logic [L:0] got, input logic [L:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got sign=%0b mag=%0d expected sign=%0b mag=%0d",
               tag, got[L], got[L-1:0], exp[L], exp[L-1:0]);
    end
  endtask

  task automatic cyc(input logic e, input logic [P-1:0] s);
    en = e;
    step = s;
    @(posedge clk);
    if (e) m_acc = m_acc + s;
    sb.push_back(m_acc);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b0;
    sb.delete();
    m_acc = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {sign_o, mag_o}, '0);
    rst_n = 1'b1;
  endtask

  task automatic settle_chk(input string tag, input logic [L:0] exp);
    repeat (3) cyc(1'b1, '0);
    chk(tag, {sign_o, mag_o}, exp);
  endtask

  task automatic park(input int idx);
    do_reset();
    cyc(1'b1, P'(idx) << K);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() >= 3) begin
      logic [P-1:0] a;
      a = sb.pop_front();
      chk({region(a), " stream with R9 latency"}, {sign_o, mag_o}, ref_out(a));
    end
  end

  initial begin
    logic [L:0] held;
    do_reset();

    park(0);              settle_chk("R8 index 0 positive zero", {1'b0, L'(0)});
    park(1);              settle_chk("R5 direct index 1", {1'b0, tab(1)});
    park(1023);           settle_chk("R5 direct index 1023", {1'b0, tab(1023)});
    park(1024);           settle_chk("R7 positive crest", {1'b0, {L{1'b1}}});
    park(1025);           settle_chk("R6 fold 1025 reads 1023", {1'b0, tab(1023)});
    park(2047);           settle_chk("R6 fold 2047 reads 1", {1'b0, tab(1)});
    park(2048);           settle_chk("R8 negative zero", {1'b1, L'(0)});
    park(2048 + 5);       settle_chk("R4 sign set third quarter", {1'b1, tab(5)});
    park(3072);           settle_chk("R7 negative crest", {1'b1, {L{1'b1}}});
    park(3072 + 2);       settle_chk("R6 fold fourth quarter", {1'b1, tab(1022)});

    do_reset();
    cyc(1'b1, P'(1) << (K - 1));
    settle_chk("R2 half fractional step stays on index 0", {1'b0, L'(0)});
    cyc(1'b1, P'(1) << (K - 1));
    settle_chk("R2 two half steps reach index 1", {1'b0, tab(1)});

    park(4095);           settle_chk("R2 top index", {1'b1, tab(1)});
    cyc(1'b1, P'(1) << K);
    settle_chk("R2 wrap to index 0", {1'b0, L'(0)});

    park(300);
    repeat (3) cyc(1'b1, '0);
    held = {sign_o, mag_o};
    for (int i = 0; i < 6; i++) cyc(1'b0, P'(32'h5A5A5 + i * 977));
    chk("R3 hold with enable low", {sign_o, mag_o}, held);
    chk("R3 held value matches index 300", held, {1'b0, tab(300)});

    do_reset();
    for (int i = 0; i < 1500; i++) cyc(1'b1, P'(1) << K);
    for (int i = 0; i < 3000; i++) cyc($urandom_range(0, 3) != 0, P'($urandom));
    for (int i = 0; i < 2000; i++) cyc(1'b1, P'($urandom_range(1, 4095)));
    repeat (3) cyc(1'b0, '0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule